// File: doc/BRIEF.md
# Supply Monitor Reset Controller

This block is the digital control logic that sits behind a supply-voltage monitor in a small microcontroller. Two comparator outputs come in as raw levels. One says the supply is under the reset threshold. The other says it is under the higher warning threshold. Each level is synchronized and then filtered so that it must hold steady for a programmable number of cycles. The filtered levels drive a core reset sequencer, a supply-OK status bit and a level-type early-warning interrupt.

The monitor has a stored enable bit and a stored reset-source select bit. Only a power-on or power-fail reset forces both bits to 1. Software writes change them, and a software reset leaves them alone. While the device is asleep, both bits read as 0 and a supply dip cannot reset the core. A wake event restores the stored values. Any flash erase or write strobe that arrives while the monitor is not armed becomes a flash-error reset, and the operation is not performed. Each reset records its cause in a one-hot register.

Top module: `supmon_rst_ctrl`

## Requirements
- R1: A power-on reset (`rst_n` low) or a power-fail reset forces the stored enable and select bits to 1, even if software had cleared them.
- R2: While enable and select are both 1 and the device is awake, a filtered below-reset-threshold level asserts `core_rst_o` and holds it for as long as that level persists. With select at 0, the same dip has no effect.
- R3: `porf_o` reads 1 after a power-on or power-fail reset and reads 0 after a software or flash-error reset.
- R4: A software reset leaves the enable and select bits at the values software last wrote.
- R5: After a sleep request, `mon_en_o` and `mon_sel_o` read 0 and a supply dip below the reset threshold does not assert `core_rst_o`.
- R6: A wake event makes `mon_en_o` and `mon_sel_o` show the last written stored values again, including a mixed 1/0 pair.
- R7: `vdd_ok_o` is 0 while the filtered warning level is active. With `irq_en_i` high, this sets `warn_irq_o`. The request stays pending until `irq_clr_i` is pulsed while the supply is above the warning threshold. A clear that arrives while the supply is still below the threshold is ignored. With `irq_en_i` low, no request is raised.
- R8: A `flash_op_i` strobe while the monitor is not armed asserts `core_rst_o` and does not pulse `flash_go_o`. While armed, the strobe pulses `flash_go_o` for one cycle, one clock after it is sampled, and no reset occurs.
- R9: Each comparator input passes through two flops. The filtered level changes only after the synchronized value has differed from it on `filt_len_i`+1 consecutive clocks. With `filt_len_i`=3, a raw pulse 3 cycles long is ignored. A held dip asserts `core_rst_o` on the 7th clock edge after the raw change, and not on the 6th.
- R10: `core_rst_o` stays high for exactly 16 clock cycles after a software reset request is sampled, and for 16 cycles after a power-fail condition ends.
- R11: `rst_cause_o` is one-hot and holds until the next reset. Bit 0 means power-on or power-fail, bit 1 means software, and bit 2 means flash error.
- R12: While `core_rst_o` is high, software reset requests and flash strobes are ignored and `rst_cause_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| below_rst_raw_i | input | 1 | Raw comparator: supply under reset threshold |
| below_warn_raw_i | input | 1 | Raw comparator: supply under warning threshold |
| filt_len_i | input | 8 | Filter stability length (cycles minus one) |
| cfg_we_i | input | 1 | Write strobe for stored enable/select |
| cfg_en_i | input | 1 | Enable value to write |
| cfg_sel_i | input | 1 | Reset-source select value to write |
| sleep_req_i | input | 1 | Enter sleep pulse |
| wake_i | input | 1 | Wake event pulse |
| sw_rst_req_i | input | 1 | Software reset request pulse |
| flash_op_i | input | 1 | Flash erase/write strobe |
| irq_en_i | input | 1 | Warning interrupt enable |
| irq_clr_i | input | 1 | Warning interrupt clear pulse |
| core_rst_o | output | 1 | Core reset, active high |
| porf_o | output | 1 | Power-on/power-fail reset flag |
| vdd_ok_o | output | 1 | Supply above warning threshold |
| warn_irq_o | output | 1 | Pending early-warning interrupt request |
| rst_cause_o | output | 3 | One-hot cause of the last reset |
| mon_en_o | output | 1 | Effective monitor enable |
| mon_sel_o | output | 1 | Effective reset-source select |
| flash_go_o | output | 1 | Flash operation accepted pulse |

## Verification
The hardest situations to reach from the ports are the ones where stored state must survive an event that looks as if it should disturb it. One is a supply dip during sleep with fully armed bits. Another is a software reset after software has cleared both bits. The stimulus first clears the bits, then issues a software reset, then sends a flash strobe, which must now become a flash-error reset. Next it re-arms, enters sleep and holds the reset comparator low for many cycles. Finally it wakes with a mixed 1/0 pair and reads the bits back. The filter boundary is probed with a pulse exactly one cycle too short, followed by a held dip sampled on both sides of the expected edge.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  localparam int unsigned CAUSE_W = 3;
  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_PWR   = 3'b001,
    CAUSE_SW    = 3'b010,
    CAUSE_FLASH = 3'b100
  } cause_e;
endpackage

// File: rtl/supmon_rst_sync.sv
module supmon_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/supmon_filter.sv
module supmon_filter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             filt_o
);
  logic             s1_q, s2_q;
  logic             filt_q, filt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // two-flop synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
    end
  end

  // stability counter next state
  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (s2_q != filt_q) begin
      if (cnt_q == len_i) begin
        filt_d = s2_q;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign filt_o = filt_q;

  assert_filt_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_q != filt_q && cnt_q != len_i) |=> $stable(filt_q));
endmodule

// File: rtl/supmon_arm.sv
module supmon_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic pf_i,
  input  logic cfg_we_i,
  input  logic cfg_en_i,
  input  logic cfg_sel_i,
  input  logic sleep_req_i,
  input  logic wake_i,
  output logic en_o,
  output logic sel_o,
  output logic sleep_o,
  output logic armed_o
);
  logic en_q, en_d, sel_q, sel_d, sleep_q, sleep_d;

  always_comb begin
    en_d    = en_q;
    sel_d   = sel_q;
    sleep_d = sleep_q;
    if (pf_i) begin
      en_d  = 1'b1;
      sel_d = 1'b1;
    end else if (cfg_we_i) begin
      en_d  = cfg_en_i;
      sel_d = cfg_sel_i;
    end
    if (wake_i)           sleep_d = 1'b0;
    else if (sleep_req_i) sleep_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b1;
      sel_q   <= 1'b1;
      sleep_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      sel_q   <= sel_d;
      sleep_q <= sleep_d;
    end
  end

  assign en_o    = en_q & ~sleep_q;
  assign sel_o   = sel_q & ~sleep_q;
  assign sleep_o = sleep_q;
  assign armed_o = en_q & sel_q & ~sleep_q;

  assert_pf_forces_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pf_i |=> (en_q && sel_q));
  assert_bits_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pf_i && !cfg_we_i) |=> ($stable(en_q) && $stable(sel_q)));
  assert_no_pf_asleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |-> !pf_i);
endmodule

// File: rtl/supmon_rst_seq.sv
module supmon_rst_seq
  import supmon_pkg::*;
#(
  parameter int unsigned STRETCH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pf_i,
  input  logic               sw_req_i,
  input  logic               flash_req_i,
  input  logic               armed_i,
  output logic               core_rst_o,
  output logic               porf_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               flash_go_o
);
  localparam int unsigned CW = (STRETCH > 2) ? $clog2(STRETCH) : 1;
  localparam logic [CW-1:0] LAST = CW'(STRETCH - 1);

  logic          rst_q, rst_d, porf_q, porf_d, go_q, go_d;
  logic [CW-1:0] cnt_q, cnt_d;
  cause_e        cause_q, cause_d;
  logic          flash_err, flash_ok, sw_ok;

  assign flash_err = flash_req_i & ~armed_i & ~rst_q;
  assign flash_ok  = flash_req_i &  armed_i & ~rst_q;
  assign sw_ok     = sw_req_i & ~rst_q;

  always_comb begin
    rst_d   = rst_q;
    cnt_d   = cnt_q;
    cause_d = cause_q;
    porf_d  = porf_q;
    go_d    = flash_ok & ~pf_i;
    if (pf_i) begin
      rst_d = 1'b1; cnt_d = '0; cause_d = CAUSE_PWR; porf_d = 1'b1;
    end else if (flash_err) begin
      rst_d = 1'b1; cnt_d = '0; cause_d = CAUSE_FLASH; porf_d = 1'b0;
    end else if (sw_ok) begin
      rst_d = 1'b1; cnt_d = '0; cause_d = CAUSE_SW; porf_d = 1'b0;
    end else if (rst_q) begin
      if (cnt_q == LAST) rst_d = 1'b0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q   <= 1'b1;
      cnt_q   <= '0;
      cause_q <= CAUSE_PWR;
      porf_q  <= 1'b1;
      go_q    <= 1'b0;
    end else begin
      rst_q   <= rst_d;
      cnt_q   <= cnt_d;
      cause_q <= cause_d;
      porf_q  <= porf_d;
      go_q    <= go_d;
    end
  end

  assign core_rst_o = rst_q;
  assign porf_o     = porf_q;
  assign cause_o    = cause_q;
  assign flash_go_o = go_q;

  assert_pf_holds_rst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pf_i |=> rst_q);
  assert_porf_after_pf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pf_i |=> porf_q);
  assert_flash_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_req_i && !armed_i && !rst_q && !pf_i) |=> (rst_q && !go_q && cause_q == CAUSE_FLASH));
  assert_cause_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cause_q) == 1);
  assert_busy_ignores_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q && !pf_i) |=> $stable(cause_q));
endmodule

// File: rtl/supmon_rst_ctrl.sv
module supmon_rst_ctrl
  import supmon_pkg::*;
#(
  parameter int unsigned FILT_W  = 8,
  parameter int unsigned STRETCH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               below_rst_raw_i,
  input  logic               below_warn_raw_i,
  input  logic [FILT_W-1:0]  filt_len_i,
  input  logic               cfg_we_i,
  input  logic               cfg_en_i,
  input  logic               cfg_sel_i,
  input  logic               sleep_req_i,
  input  logic               wake_i,
  input  logic               sw_rst_req_i,
  input  logic               flash_op_i,
  input  logic               irq_en_i,
  input  logic               irq_clr_i,
  output logic               core_rst_o,
  output logic               porf_o,
  output logic               vdd_ok_o,
  output logic               warn_irq_o,
  output logic [CAUSE_W-1:0] rst_cause_o,
  output logic               mon_en_o,
  output logic               mon_sel_o,
  output logic               flash_go_o
);
  localparam int unsigned NCH = 2;  // channel 0: reset level, 1: warning level

  logic           srst_n;
  logic [NCH-1:0] raw_vec, filt_vec;
  logic           armed, sleep_st, pf;
  logic           warn_q, warn_d, irq_q, irq_d;

  supmon_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .arst_n(rst_n), .srst_n_o(srst_n)
  );

  assign raw_vec = {below_warn_raw_i, below_rst_raw_i};

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    supmon_filter #(.CNT_W(FILT_W)) u_filt (
      .clk(clk), .rst_n(srst_n), .raw_i(raw_vec[g]),
      .len_i(filt_len_i), .filt_o(filt_vec[g])
    );
  end

  assign pf = armed & filt_vec[0];

  supmon_arm u_arm (
    .clk(clk), .rst_n(srst_n), .pf_i(pf),
    .cfg_we_i(cfg_we_i), .cfg_en_i(cfg_en_i), .cfg_sel_i(cfg_sel_i),
    .sleep_req_i(sleep_req_i), .wake_i(wake_i),
    .en_o(mon_en_o), .sel_o(mon_sel_o), .sleep_o(sleep_st), .armed_o(armed)
  );

  supmon_rst_seq #(.STRETCH(STRETCH)) u_seq (
    .clk(clk), .rst_n(srst_n), .pf_i(pf),
    .sw_req_i(sw_rst_req_i), .flash_req_i(flash_op_i), .armed_i(armed),
    .core_rst_o(core_rst_o), .porf_o(porf_o), .cause_o(rst_cause_o),
    .flash_go_o(flash_go_o)
  );

  // warning status and level interrupt
  always_comb begin
    warn_d = filt_vec[1];
    irq_d  = irq_q;
    if (filt_vec[1] && irq_en_i)       irq_d = 1'b1;
    else if (irq_clr_i && !filt_vec[1]) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      warn_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      warn_q <= warn_d;
      irq_q  <= irq_d;
    end
  end

  assign vdd_ok_o   = ~warn_q;
  assign warn_irq_o = irq_q;

  assert_irq_pending_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (irq_q && filt_vec[1]) |=> irq_q);
  assert_sleep_no_reset_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (sleep_st && !core_rst_o && !sw_rst_req_i && !flash_op_i) |=> !core_rst_o);
endmodule

// File: tb/supmon_rst_ctrl_bench.sv
`timescale 1ns/1ps
module supmon_rst_ctrl_bench;
  localparam int S_RST = 0, S_PORF = 1, S_OK = 2, S_IRQ = 3, S_CAUSE = 4,
                 S_EN = 5, S_SEL = 6, S_GO = 7;

  typedef struct { string req; int sig; int val; } exp_t;
  exp_t exp_q[$];

  logic clk = 1'b0;
  logic rst_n;
  logic below_rst, below_warn, cfg_we, cfg_en, cfg_sel, sleep_req, wake;
  logic sw_rst, flash_op, irq_en, irq_clr;
  logic [7:0] filt_len;
  logic core_rst, porf, vdd_ok, warn_irq, mon_en, mon_sel, flash_go;
  logic [2:0] cause;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  supmon_rst_ctrl u_supmon_rst_ctrl (
    .clk(clk), .rst_n(rst_n), .below_rst_raw_i(below_rst), .below_warn_raw_i(below_warn),
    .filt_len_i(filt_len), .cfg_we_i(cfg_we), .cfg_en_i(cfg_en), .cfg_sel_i(cfg_sel),
    .sleep_req_i(sleep_req), .wake_i(wake), .sw_rst_req_i(sw_rst), .flash_op_i(flash_op),
    .irq_en_i(irq_en), .irq_clr_i(irq_clr), .core_rst_o(core_rst), .porf_o(porf),
    .vdd_ok_o(vdd_ok), .warn_irq_o(warn_irq), .rst_cause_o(cause), .mon_en_o(mon_en),
    .mon_sel_o(mon_sel), .flash_go_o(flash_go)
  );

  function automatic int peek(int sig);
    case (sig)
      S_RST:   return int'(core_rst);
      S_PORF:  return int'(porf);
      S_OK:    return int'(vdd_ok);
      S_IRQ:   return int'(warn_irq);
      S_CAUSE: return int'(cause);
      S_EN:    return int'(mon_en);
      S_SEL:   return int'(mon_sel);
      default: return int'(flash_go);
    endcase
  endfunction

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic expect_sig(string req, int sig, int val);
    exp_t it;
    it.req = req; it.sig = sig; it.val = val;
    exp_q.push_back(it);
  endtask

  // monitor: pops expectations shortly after each falling edge
  always @(negedge clk) begin
    #2;
    while (exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      chk(it.req, peek(it.sig), it.val);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; step(1); s = 1'b0;
  endtask

  task automatic write_cfg(logic e, logic s);
    cfg_en = e; cfg_sel = s; pulse(cfg_we);
  endtask

  task automatic do_por();
    rst_n = 1'b0; step(2); rst_n = 1'b1; step(3);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cnt;
    rst_n = 0; below_rst = 0; below_warn = 0; cfg_we = 0; cfg_en = 0; cfg_sel = 0;
    sleep_req = 0; wake = 0; sw_rst = 0; flash_op = 0; irq_en = 0; irq_clr = 0;
    filt_len = 8'd3;
    step(1);
    do_por();
    expect_sig("R10 reset held after POR", S_RST, 1);
    expect_sig("R3 porf after POR", S_PORF, 1);
    expect_sig("R11 cause after POR", S_CAUSE, 1);
    expect_sig("R1 en after POR", S_EN, 1);
    expect_sig("R1 sel after POR", S_SEL, 1);
    expect_sig("R7 vdd_ok at reset", S_OK, 1);
    expect_sig("R7 irq at reset", S_IRQ, 0);
    step(30);
    expect_sig("R10 reset released after POR", S_RST, 0);

    // R10 software reset stretch
    step(1);
    pulse(sw_rst);
    cnt = 0;
    while (core_rst && cnt < 100) begin cnt++; step(1); end
    chk("R10 sw reset length", cnt, 16);
    expect_sig("R11 cause sw", S_CAUSE, 2);
    expect_sig("R3 porf after sw", S_PORF, 0);

    // R4 cleared bits survive a software reset
    step(1);
    write_cfg(1'b0, 1'b0);
    expect_sig("R4 en written 0", S_EN, 0);
    pulse(sw_rst);
    step(30);
    expect_sig("R4 en kept after sw", S_EN, 0);
    expect_sig("R4 sel kept after sw", S_SEL, 0);

    // R8 flash while disarmed
    step(1);
    pulse(flash_op);
    expect_sig("R8 flash err resets", S_RST, 1);
    expect_sig("R8 flash not performed", S_GO, 0);
    step(1);
    expect_sig("R11 cause flash", S_CAUSE, 4);
    expect_sig("R3 porf after flash", S_PORF, 0);
    step(30);

    // R12 requests ignored during stretch
    pulse(sw_rst);
    step(2);
    pulse(flash_op);
    step(30);
    expect_sig("R12 cause unchanged", S_CAUSE, 2);
    step(1);

    // R8 armed flash passes
    write_cfg(1'b1, 1'b1);
    pulse(flash_op);
    expect_sig("R8 flash go", S_GO, 1);
    expect_sig("R8 no reset when armed", S_RST, 0);
    step(1);
    expect_sig("R8 go is one pulse", S_GO, 0);

    // R9 glitch one cycle short
    step(2);
    below_rst = 1; step(3); below_rst = 0;
    step(15);
    expect_sig("R9 short glitch ignored", S_RST, 0);

    // R9 held dip timing, R2 hold
    step(1);
    below_rst = 1;
    step(6);
    expect_sig("R9 not yet at edge 6", S_RST, 0);
    step(1);
    expect_sig("R9 reset at edge 7", S_RST, 1);
    step(1);
    expect_sig("R3 porf after power-fail", S_PORF, 1);
    expect_sig("R11 cause power-fail", S_CAUSE, 1);
    step(25);
    expect_sig("R2 reset held during dip", S_RST, 1);
    below_rst = 0;
    step(20);
    expect_sig("R10 still stretched after dip", S_RST, 1);
    step(5);
    expect_sig("R2 released after dip", S_RST, 0);

    // R2 not selected -> no reset
    step(1);
    write_cfg(1'b1, 1'b0);
    below_rst = 1; step(25);
    expect_sig("R2 unselected dip ignored", S_RST, 0);
    below_rst = 0; step(15);

    // R5 sleep suppresses
    write_cfg(1'b1, 1'b1);
    pulse(sleep_req);
    expect_sig("R5 en reads 0 asleep", S_EN, 0);
    expect_sig("R5 sel reads 0 asleep", S_SEL, 0);
    below_rst = 1; step(25);
    expect_sig("R5 no reset asleep", S_RST, 0);
    below_rst = 0; step(15);
    pulse(wake);
    expect_sig("R6 en restored", S_EN, 1);
    expect_sig("R6 sel restored", S_SEL, 1);
    step(1);

    // R6 mixed pair
    write_cfg(1'b1, 1'b0);
    pulse(sleep_req);
    step(3);
    pulse(wake);
    expect_sig("R6 en mixed", S_EN, 1);
    expect_sig("R6 sel mixed", S_SEL, 0);
    step(1);

    // R7 warning interrupt
    irq_en = 1; below_warn = 1; step(10);
    expect_sig("R7 vdd_ok low", S_OK, 0);
    expect_sig("R7 irq raised", S_IRQ, 1);
    step(1);
    pulse(irq_clr);
    expect_sig("R7 clear ignored while low", S_IRQ, 1);
    below_warn = 0; step(10);
    expect_sig("R7 vdd_ok back", S_OK, 1);
    expect_sig("R7 irq still pending", S_IRQ, 1);
    step(1);
    pulse(irq_clr);
    expect_sig("R7 irq cleared", S_IRQ, 0);
    irq_en = 0; below_warn = 1; step(10);
    expect_sig("R7 vdd_ok low no irq", S_OK, 0);
    expect_sig("R7 no irq when disabled", S_IRQ, 0);
    below_warn = 0; step(10);

    // R1 POR with cleared bits
    write_cfg(1'b0, 1'b0);
    do_por();
    expect_sig("R1 en forced by POR", S_EN, 1);
    expect_sig("R1 sel forced by POR", S_SEL, 1);
    expect_sig("R11 cause POR again", S_CAUSE, 1);
    step(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule